// File: doc/BRIEF.md
# SPI Flash Command Front-End

This block is the slave-side serial front end of a NOR flash device. It watches the serial clock, the active-low chip select and the serial data input, and drives the serial data output together with an output-enable for the pad's tristate buffer. All pins are oversampled on the core clock through synchronizer chains. Rising serial-clock edges shift in bits and falling edges shift out bits, so serial-clock modes 0 and 3 both work.

Each frame starts with an 8-bit command byte. The command byte is checked against the set of commands the core accepts. For an accepted command, three address bytes follow. The block then raises a single-cycle strobe carrying the command byte and the 21 low address bits. For the read command it then streams bytes supplied by the core onto the output pin, and pulses a take signal each time it loads one.

Two framing rules matter most. An unrecognised command byte makes the block deaf to the data input for the rest of the frame. Deselecting before the header is complete throws the partial command away without a trace.

Top module: `spi_cmd_frontend`

## Requirements
- R1: Data-input bits are captured on rising serial-clock edges while selected, most significant bit first; the first eight bits of a frame form the command byte.
- R2: Three address bytes follow an accepted command byte, most significant first; the three top address bits are dropped and `cmd_addr` carries address bits 20..0.
- R3: For command bytes 02h, 03h, 20h, 52h and D8h, `cmd_valid` is high for exactly one core cycle after the 32nd captured bit, with `cmd_opcode` and `cmd_addr` valid in that cycle.
- R4: Any other command byte issues no command, and all later input bits of that frame are ignored; the next frame (deselect then select) is decoded normally.
- R5: If chip select goes high before the 32nd bit is captured, no command is issued; a deselect seen in the same sampled cycle as the 32nd rising edge also aborts.
- R6: Bits received in an aborted frame never carry into the next frame; every frame starts decoding from bit 0.
- R7: After a read (03h) header, the first data bit appears on the falling edge that follows the last address bit, and bytes are sent most significant bit first. Each byte is loaded from `rd_byte` on its first falling edge, and `rd_take` pulses once per load.
- R8: `spi_so_oe` is low while deselected and during every header; `spi_so` is 0 whenever `spi_so_oe` is low.
- R9: Both serial-clock idle levels work: with an idle-high clock, the falling edge before the first bit neither captures nor drives data.
- R10: During reset `cmd_valid`, `rd_take` and `spi_so_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for the `spi_so` pad |
| rd_byte | input | 8 | Next read byte offered by the core |
| rd_take | output | 1 | One-cycle pulse: `rd_byte` was loaded |
| cmd_valid | output | 1 | One-cycle pulse: a complete accepted header arrived |
| cmd_opcode | output | 8 | Command byte of the current frame |
| cmd_addr | output | 21 | Effective address of the current frame |

## Verification
The closing chip-select edge and the rising edge that carries the last header bit can be seen in the same sampled cycle. Here completion and abort compete. The bench provokes this by raising chip select on the same core-clock step as the 32nd rising serial-clock edge, so that both pass through equal-length synchronizers. It judges the result by requiring that no command strobe appears. A reference queue of expected commands is compared against `cmd_valid` on every clock, and a read header is checked from its first output bit, so any strobe that escapes or is delayed is caught.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int OPC_W      = 8;
  localparam int ADDR_W     = 24;
  localparam int EFF_ADDR_W = 21;
  localparam int HDR_BITS   = OPC_W + ADDR_W;
  localparam int BYTE_W     = 8;

  localparam logic [OPC_W-1:0] OPC_PROG  = 8'h02;
  localparam logic [OPC_W-1:0] OPC_READ  = 8'h03;
  localparam logic [OPC_W-1:0] OPC_ER_S  = 8'h20;
  localparam logic [OPC_W-1:0] OPC_ER_M  = 8'h52;
  localparam logic [OPC_W-1:0] OPC_ER_L  = 8'hD8;

  typedef enum logic [1:0] {
    HS_OPC  = 2'd0,
    HS_ADDR = 2'd1,
    HS_LOCK = 2'd2,
    HS_TAIL = 2'd3
  } hdr_state_e;

  function automatic logic opc_known(input logic [OPC_W-1:0] o);
    return (o == OPC_PROG) || (o == OPC_READ) || (o == OPC_ER_S) ||
           (o == OPC_ER_M) || (o == OPC_ER_L);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_raw,
  input  logic cs_n_raw,
  input  logic si_raw,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_hi,
  output logic si_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b010; // {si, cs_n, sck}

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sck_d_q;

  assign raw = {si_raw, cs_n_raw, sck_raw};

  for (genvar g = 0; g < NSIG; g++) begin : g_chain
    logic [STAGES-1:0] ch_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_q <= {STAGES{RST_VAL[g]}};
      else        ch_q <= {ch_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = ch_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d_q <= 1'b0;
    else        sck_d_q <= synced[0];
  end

  assign sck_rise = synced[0] & ~sck_d_q;
  assign sck_fall = ~synced[0] & sck_d_q;
  assign cs_hi    = synced[1];
  assign si_s     = synced[2];
endmodule

// File: rtl/spi_hdr_rx.sv
module spi_hdr_rx
  import sfe_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_rise,
  input  logic                  cs_hi,
  input  logic                  si,
  output logic                  cmd_valid,
  output logic [OPC_W-1:0]      cmd_opcode,
  output logic [EFF_ADDR_W-1:0] cmd_addr
);
  localparam int CNT_W = $clog2(HDR_BITS + 1);

  hdr_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OPC_W-1:0]  opc_q, opc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              valid_q, valid_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opc_d   = opc_q;
    addr_d  = addr_q;
    valid_d = 1'b0;
    if (cs_hi) begin
      state_d = HS_OPC;
      cnt_d   = '0;
      opc_d   = '0;
      addr_d  = '0;
    end else if (sck_rise) begin
      unique case (state_q)
        HS_OPC: begin
          opc_d = {opc_q[OPC_W-2:0], si};
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(OPC_W - 1))
            state_d = opc_known(opc_d) ? HS_ADDR : HS_LOCK;
        end
        HS_ADDR: begin
          addr_d = {addr_q[ADDR_W-2:0], si};
          cnt_d  = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
            valid_d = 1'b1;
            state_d = HS_TAIL;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_OPC;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      addr_q  <= addr_d;
      valid_q <= valid_d;
    end
  end

  assign cmd_valid  = valid_q;
  assign cmd_opcode = opc_q;
  assign cmd_addr   = addr_q[EFF_ADDR_W-1:0];

  assert_valid_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_valid_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(sck_rise));
  assert_lock_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_LOCK) |=> !valid_q);
  assert_deselect_no_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !valid_q);
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx
  import sfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_fall,
  input  logic              cs_hi,
  input  logic              start,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              so,
  output logic              so_oe,
  output logic              rd_take
);
  localparam int LEFT_W = $clog2(BYTE_W);

  logic              armed_q, armed_d;
  logic              oe_q, oe_d;
  logic              so_q, so_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              take_q, take_d;

  always_comb begin
    armed_d = armed_q;
    oe_d    = oe_q;
    so_d    = so_q;
    sh_d    = sh_q;
    left_d  = left_q;
    take_d  = 1'b0;
    if (cs_hi) begin
      armed_d = 1'b0;
      oe_d    = 1'b0;
      so_d    = 1'b0;
      sh_d    = '0;
      left_d  = '0;
    end else begin
      if (start) armed_d = 1'b1;
      if (sck_fall && armed_q) begin
        oe_d = 1'b1;
        if (left_q == '0) begin
          so_d   = rd_byte[BYTE_W-1];
          sh_d   = rd_byte[BYTE_W-2:0];
          left_d = LEFT_W'(BYTE_W - 1);
          take_d = 1'b1;
        end else begin
          so_d   = sh_q[BYTE_W-2];
          sh_d   = {sh_q[BYTE_W-3:0], 1'b0};
          left_d = left_q - LEFT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      so_q    <= 1'b0;
      sh_q    <= '0;
      left_q  <= '0;
      take_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      oe_q    <= oe_d;
      so_q    <= so_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      take_q  <= take_d;
    end
  end

  assign so      = so_q;
  assign so_oe   = oe_q;
  assign rd_take = take_q;

  assert_oe_off_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !oe_q);
  assert_so_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && $past(oe_q) && !$past(sck_fall)) |-> $stable(so_q));
  assert_take_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q);
  assert_oe_needs_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(armed_q));
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import sfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sck,
  input  logic                  spi_cs_n,
  input  logic                  spi_si,
  output logic                  spi_so,
  output logic                  spi_so_oe,
  input  logic [BYTE_W-1:0]     rd_byte,
  output logic                  rd_take,
  output logic                  cmd_valid,
  output logic [OPC_W-1:0]      cmd_opcode,
  output logic [EFF_ADDR_W-1:0] cmd_addr
);
  logic [1:0] rst_q;
  logic       rst_s_n;
  logic       sck_rise, sck_fall, cs_hi, si_s;
  logic       rd_start;
  logic       so_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .sck_raw  (spi_sck),
    .cs_n_raw (spi_cs_n),
    .si_raw   (spi_si),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_hi    (cs_hi),
    .si_s     (si_s)
  );

  spi_hdr_rx u_hdr (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .sck_rise   (sck_rise),
    .cs_hi      (cs_hi),
    .si         (si_s),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .cmd_addr   (cmd_addr)
  );

  assign rd_start = cmd_valid && (cmd_opcode == OPC_READ);

  spi_rd_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .sck_fall (sck_fall),
    .cs_hi    (cs_hi),
    .start    (rd_start),
    .rd_byte  (rd_byte),
    .so       (so_raw),
    .so_oe    (spi_so_oe),
    .rd_take  (rd_take)
  );

  assign spi_so = so_raw & spi_so_oe;

  assert_cmd_is_known_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_valid |-> opc_known(cmd_opcode));
  assert_so_quiet_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !spi_so_oe |-> !spi_so);
endmodule

// File: tb/spi_cmd_frontend_tb.sv
module spi_cmd_frontend_tb_top;
  localparam int H = 6;

  logic        clk;
  logic        rst_n;
  logic        sck, cs_n, si;
  logic        so, so_oe;
  logic [7:0]  rd_byte;
  logic        rd_take, cmd_valid;
  logic [7:0]  cmd_opcode;
  logic [20:0] cmd_addr;

  int n_chk = 0;
  int n_fail = 0;
  int rd_idx = 0;
  bit done = 0;
  string cur_req = "R3";

  typedef struct {
    logic [7:0]  op;
    logic [20:0] a;
  } exp_t;
  exp_t exq[$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] stub_byte(input int k);
    return 8'((k * 37) ^ 8'h5A);
  endfunction

  assign rd_byte = stub_byte(rd_idx);
  always @(posedge clk) if (rd_take) rd_idx <= rd_idx + 1;

  spi_cmd_frontend dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sck    (sck),
    .spi_cs_n   (cs_n),
    .spi_si     (si),
    .spi_so     (so),
    .spi_so_oe  (so_oe),
    .rd_byte    (rd_byte),
    .rd_take    (rd_take),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .cmd_addr   (cmd_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (exq.size() == 0) begin
        check(1'b0, cur_req, "unexpected cmd_valid", {8'h0, cmd_opcode}, 0);
      end else begin
        exp_t e;
        e = exq.pop_front();
        check(cmd_opcode == e.op, "R1", "cmd_opcode", cmd_opcode, e.op);
        check(cmd_addr == e.a, "R2", "cmd_addr", cmd_addr, e.a);
      end
    end
  end

  task automatic frame(input logic [63:0] bits, input int nbits, input bit mode3,
                       input int rd_bytes, input bit abort_last, input string req);
    int base;
    int total;
    int k;
    int b;
    logic [7:0] eb;
    cur_req = req;
    base = rd_idx;
    total = nbits + rd_bytes * 8;
    sck = mode3; cs_n = 1'b1; si = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      sck = 1'b0;
      si = (i < nbits) ? bits[63 - i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i >= 32 && rd_bytes > 0) begin
        k = (i - 32) / 8;
        b = 7 - ((i - 32) % 8);
        eb = stub_byte(base + k);
        check(so_oe === 1'b1 && so === eb[b], "R7", "read bit",
              {so_oe, so}, {1'b1, eb[b]});
      end
      if (i == 16)
        check(so_oe === 1'b0 && so === 1'b0, "R8", "oe during header", {so_oe, so}, 0);
      sck = 1'b1;
      if (abort_last && i == total - 1) cs_n = 1'b1;
      repeat (H) @(negedge clk);
    end
    if (!mode3) begin
      sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(exq.size() == 0, req, "commands still pending", exq.size(), 0);
    exq.delete();
    check(so_oe === 1'b0, "R8", "oe after deselect", so_oe, 0);
  endtask

  task automatic expect_cmd(input logic [7:0] op, input logic [20:0] a);
    exp_t e;
    e.op = op;
    e.a = a;
    exq.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0;
    repeat (5) @(negedge clk);
    // R10: reset state
    check(cmd_valid === 1'b0 && rd_take === 1'b0 && so_oe === 1'b0, "R10",
          "outputs in reset", {cmd_valid, rd_take, so_oe}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2 R3: program, top address bits dropped, mode 0
    expect_cmd(8'h02, 21'h1FABCD);
    frame({8'h02, 24'hFFABCD, 32'h0}, 32, 1'b0, 0, 1'b0, "R3");
    // R9: idle-high clock, small erase
    expect_cmd(8'h20, 21'h000001);
    frame({8'h20, 24'h000001, 32'h0}, 32, 1'b1, 0, 1'b0, "R9");
    expect_cmd(8'h52, 21'h0A5A5A);
    frame({8'h52, 24'h4A5A5A, 32'h0}, 32, 1'b0, 0, 1'b0, "R3");
    expect_cmd(8'hD8, 21'h100000);
    frame({8'hD8, 24'hF00000, 32'h0}, 32, 1'b1, 0, 1'b0, "R2");
    // R7: read stream in both modes
    expect_cmd(8'h03, 21'h1FFFFF);
    frame({8'h03, 24'hFFFFFF, 32'h0}, 32, 1'b0, 3, 1'b0, "R7");
    expect_cmd(8'h03, 21'h012345);
    frame({8'h03, 24'h012345, 32'h0}, 32, 1'b1, 2, 1'b0, "R9");
    // R4: unknown command then an embedded read header must be ignored
    frame({8'h9F, 8'h03, 16'h1234, 8'h56, 24'h0}, 56, 1'b0, 0, 1'b0, "R4");
    expect_cmd(8'hD8, 21'h000100);
    frame({8'hD8, 24'h000100, 32'h0}, 32, 1'b0, 0, 1'b0, "R4");
    // R6: five stray bits then a clean frame
    frame({5'b00000, 59'h0}, 5, 1'b0, 0, 1'b0, "R6");
    expect_cmd(8'h20, 21'h0ABCDE);
    frame({8'h20, 24'h0ABCDE, 32'h0}, 32, 1'b0, 0, 1'b0, "R6");
    // R5: deselect mid-address, and together with the last bit
    frame({8'h02, 12'hABC, 44'h0}, 20, 1'b0, 0, 1'b0, "R5");
    frame({8'hD8, 24'h123456, 32'h0}, 32, 1'b0, 0, 1'b1, "R5");
    frame({8'h52, 24'h00FF00, 32'h0}, 32, 1'b1, 0, 1'b1, "R5");
    expect_cmd(8'h02, 21'h00FF00);
    frame({8'h02, 24'h00FF00, 32'h0}, 32, 1'b1, 0, 1'b0, "R6");

    finish_run();
  end
endmodule